// File: doc/BRIEF.md
# Q15 Multiply-Accumulate Datapath

This block multiplies two 16-bit signed fractions held in operand registers H and I. In both operands the radix point sits just below the sign bit. The raw product is shifted left by one place so that its radix point sits just below bit 31, and bit 0 is forced to zero. The aligned 32-bit value is held in a product register. It is then sign-extended and added into a 36-bit accumulator, whose four extra high bits absorb growth over long runs of accumulation.

A single `start` strobe launches a fixed sequence that runs over four steps: multiply, accumulate, copy H into a side register, and reload H and I from two operand words. The reload step waits until `word_valid` is high. It then takes `x_word` into H and `y_word` into I, and raises `done` for one cycle. A typical loop therefore multiplies the pair loaded by the previous pass while the next pair is fetched. Squaring the most negative value (−1 × −1) gets special treatment: the accumulator receives +1.0, the product register shows the 32-bit pattern of −1, and the overflow flag is set.

Top module: `fmac_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the product, the overflow flag, the side register, `done` and both operand registers H and I.
- R2: If `start` is accepted at clock edge k, then at edge k+1 the product becomes (H × I) × 2 as a 32-bit two's-complement value, so bit 0 is always 0.
- R3: At edge k+2 the accumulator becomes (accumulator + product sign-extended to 36 bits) modulo 2^36. At all other edges it holds its value.
- R4: When H and I both equal 0x8000, the product becomes 0x80000000, the accumulator grows by 0x0_8000_0000 (+1.0), and the overflow flag is set at edge k+1.
- R5: The overflow flag is cleared at edge k+1 for any operand pair other than 0x8000 × 0x8000, and it holds its value until the next multiply.
- R6: At edge k+3 the side register `iz_word` takes the H value that was used for the multiply.
- R7: From edge k+4 on, the block waits for `word_valid`. At the first edge where it is high, H takes `x_word` and I takes `y_word`, and the next multiply uses these values.
- R8: `done` is high for exactly one cycle, after the edge at which the operand words are taken.
- R9: `start` is ignored while a sequence is running, and `word_valid` is ignored outside the reload step. Neither changes any output or operand register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one multiply-accumulate sequence when idle |
| x_word | input | 16 | Next H operand word |
| y_word | input | 16 | Next I operand word |
| word_valid | input | 1 | Operand words present during the reload step |
| product | output | 32 | Aligned Q31 product |
| acc | output | 36 | Accumulator with 4 guard bits |
| ovf | output | 1 | Set by the −1 × −1 case |
| iz_word | output | 16 | Copy of H taken after accumulation |
| done | output | 1 | One-cycle pulse after operand reload |

## Verification
The multiplier is tried with the following operand patterns:
- Small positive fractions, to check the one-place alignment.
- Mixed-sign pairs, to check sign extension into the guard bits.
- Repeated 0x8000 × 0x8000 pairs, which push the accumulator past 2^36 and show the modulo wrap.
- The adjacent pair 0x8000 × 0x7FFF, which must clear the flag. This separates a true −1 × −1 test from a test on one operand.

Reloads are run with `word_valid` delayed by several cycles. Stray `start` pulses during a run and `word_valid` pulses while idle show that the sequencer ignores input outside its own step.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MULT  = 3'd1,
    ST_ACCUM = 3'd2,
    ST_MOVE  = 3'd3,
    ST_LOAD  = 3'd4
  } fmac_state_t;
endpackage

// File: rtl/fmac_ctrl.sv
module fmac_ctrl
  import fmac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic word_valid,
  output logic mult_fire,
  output logic acc_fire,
  output logic move_fire,
  output logic load_fire,
  output logic done
);
  fmac_state_t state_q, state_d;

  assign mult_fire = (state_q == ST_MULT);
  assign acc_fire  = (state_q == ST_ACCUM);
  assign move_fire = (state_q == ST_MOVE);
  assign load_fire = (state_q == ST_LOAD) && word_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_MULT;
      ST_MULT:  state_d = ST_ACCUM;
      ST_ACCUM: state_d = ST_MOVE;
      ST_MOVE:  state_d = ST_LOAD;
      ST_LOAD:  if (word_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= load_fire;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  fire_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mult_fire, acc_fire, move_fire, load_fire}));
endmodule

// File: rtl/fmac_mul.sv
module fmac_mul #(
  parameter int OP_W = 16,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [OP_W-1:0]   op_h,
  input  logic [OP_W-1:0]   op_i,
  output logic [PROD_W-1:0] prod,
  output logic              neg_one
);
  localparam logic [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};

  function automatic logic [PROD_W-1:0] q_align(input logic [OP_W-1:0] a,
                                                input logic [OP_W-1:0] b);
    logic signed [PROD_W-1:0] raw;
    raw = PROD_W'($signed(a)) * PROD_W'($signed(b));
    return raw << 1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      prod    <= '0;
      neg_one <= 1'b0;
    end else if (en) begin
      prod    <= q_align(op_h, op_i);
      neg_one <= (op_h == MOST_NEG) && (op_i == MOST_NEG);
    end
  end

  // R2
  prod_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    prod[0] == 1'b0);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(neg_one) && $stable(prod));
endmodule

// File: rtl/fmac_acc.sv
module fmac_acc #(
  parameter int PROD_W = 32,
  parameter int GUARD_W = 4,
  localparam int ACC_W = PROD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PROD_W-1:0] prod,
  input  logic              neg_one,
  output logic [ACC_W-1:0]  acc
);
  localparam logic [ACC_W-1:0] PLUS_ONE = ACC_W'(1) << (PROD_W - 1);

  function automatic logic [ACC_W-1:0] addend(input logic [PROD_W-1:0] p,
                                              input logic n1);
    return n1 ? PLUS_ONE : {{GUARD_W{p[PROD_W-1]}}, p};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (en) acc <= acc + addend(prod, neg_one);
  end

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

  // R4
  neg_one_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (en && neg_one) |=> acc == $past(acc) + PLUS_ONE);
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit #(
  parameter int OP_W = 16,
  parameter int GUARD_W = 4,
  localparam int PROD_W = 2 * OP_W,
  localparam int ACC_W = PROD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   x_word,
  input  logic [OP_W-1:0]   y_word,
  input  logic              word_valid,
  output logic [PROD_W-1:0] product,
  output logic [ACC_W-1:0]  acc,
  output logic              ovf,
  output logic [OP_W-1:0]   iz_word,
  output logic              done
);
  logic mult_fire, acc_fire, move_fire, load_fire;
  logic [OP_W-1:0] h_q, i_q;

  fmac_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .word_valid(word_valid),
    .mult_fire(mult_fire), .acc_fire(acc_fire), .move_fire(move_fire),
    .load_fire(load_fire), .done(done)
  );

  fmac_mul #(.OP_W(OP_W)) u_mul (
    .clk(clk), .rst(rst), .en(mult_fire), .op_h(h_q), .op_i(i_q),
    .prod(product), .neg_one(ovf)
  );

  fmac_acc #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_acc (
    .clk(clk), .rst(rst), .en(acc_fire), .prod(product), .neg_one(ovf),
    .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q     <= '0;
      i_q     <= '0;
      iz_word <= '0;
    end else begin
      if (move_fire) iz_word <= h_q;
      if (load_fire) begin
        h_q <= x_word;
        i_q <= y_word;
      end
    end
  end

  // R6
  iz_copy_chk: assert property (@(posedge clk) disable iff (rst)
    move_fire |=> iz_word == $past(h_q));

  // R7
  operand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_fire |=> $stable(h_q) && $stable(i_q));
endmodule

// File: tb/fmac_unit_tb.sv
module fmac_unit_tb;
  logic clk = 1'b0;
  logic rst, start, word_valid;
  logic [15:0] x_word, y_word;
  logic [31:0] product;
  logic [35:0] acc;
  logic ovf, done;
  logic [15:0] iz_word;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int          m_step = 0;
  logic [15:0] m_h = 0, m_i = 0, m_iz = 0;
  logic [31:0] m_prod = 0;
  longint      m_acc = 0;
  bit          m_ovf = 0, m_done = 0;

  always #10 clk = ~clk;

  fmac_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .x_word(x_word), .y_word(y_word),
    .word_valid(word_valid), .product(product), .acc(acc), .ovf(ovf),
    .iz_word(iz_word), .done(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_h = 0; m_i = 0; m_iz = 0; m_prod = 0;
      m_acc = 0; m_ovf = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (m_step)
        0: if (start) m_step = 1;
        1: begin
          longint p;
          p = longint'($signed(m_h)) * longint'($signed(m_i)) * 2;
          m_prod = p[31:0];
          m_ovf = (m_h == 16'h8000) && (m_i == 16'h8000);
          m_step = 2;
        end
        2: begin
          if (m_ovf) m_acc = m_acc + 64'h8000_0000;
          else m_acc = m_acc + longint'($signed(m_prod));
          m_acc = m_acc & 64'hF_FFFF_FFFF;
          m_step = 3;
        end
        3: begin m_iz = m_h; m_step = 4; end
        default: if (word_valid) begin
          m_h = x_word; m_i = y_word; m_done = 1; m_step = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 product", product, m_prod);
      check("R3 acc", acc, m_acc);
      check("R5 ovf", ovf, m_ovf);
      check("R6 iz_word", iz_word, m_iz);
      check("R8 done", done, m_done);
    end
  end

  task automatic run_mac(input logic [15:0] nx, input logic [15:0] ny,
                         input int delay, input bit poke);
    start = 1'b1;
    @(negedge clk);
    start = poke;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    repeat (delay) @(negedge clk);
    x_word = nx; y_word = ny; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 0; word_valid = 0; x_word = 0; y_word = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 product", product, 0);
    check("R1 acc", acc, 0);
    check("R1 ovf", ovf, 0);
    check("R1 iz", iz_word, 0);
    check("R1 done", done, 0);

    // prime: 0 x 0, load 0.5 and 0.25
    run_mac(16'h4000, 16'h2000, 0, 0);
    run_mac(16'h8000, 16'h8000, 3, 1);
    check("R2 aligned product", product, 32'h1000_0000);
    check("R7 loaded pair used", acc, 36'h0_1000_0000);
    // R4 minus-one case
    run_mac(16'h8000, 16'h7FFF, 0, 0);
    check("R4 product", product, 32'h8000_0000);
    check("R4 acc", acc, 36'h0_9000_0000);
    check("R4 ovf", ovf, 1);
    // R5 adjacent pair clears flag
    run_mac(16'h1234, 16'hFEDC, 2, 1);
    check("R5 ovf cleared", ovf, 0);
    check("R5 product", product, 32'h8001_0000);

    // R9 word_valid while idle is ignored
    x_word = 16'h7777; y_word = 16'h7777; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    @(negedge clk);
    run_mac(16'h7FFF, 16'h8000, 0, 1);
    check("R9 idle valid ignored", iz_word, 16'h1234);

    // mixed signs
    for (int n = 0; n < 6; n++)
      run_mac(16'h7FFF, 16'h8000, n % 3, n[0]);
    // R3 wrap: repeated +1.0 additions pass 2^36
    run_mac(16'h8000, 16'h8000, 0, 0);
    for (int n = 0; n < 40; n++)
      run_mac(16'h8000, 16'h8000, 1, 0);
    run_mac(16'h0003, 16'hFFFB, 0, 0);
    run_mac(16'h0000, 16'h0000, 0, 0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule